// File: doc/BRIEF.md
# Vector Step Start/Stop Controller

This block decides when a tester steps through its stored vectors. Five clock-like sources (drive clock, pod sync, internal oscillator, RAM strobe and a decrement source used while loading vectors) and three control inputs (enable, start, stop) arrive asynchronously. A single system clock samples them through synchronizers and detects their edges. A small write port programs a configuration register and a source-select register. Each qualifying edge of the chosen source produces a one-cycle step pulse, but only while the start/stop gate is open, the enable condition holds and the address counter has not run down to zero.

Every step decrements the vector address counter. In drive mode it also captures the current vector word into an output register; in load mode it only decrements. The gate opens either at once, through a force-start configuration write, or on a START edge of programmable polarity. It closes on a STOP edge of programmable polarity when stopping is enabled, or on a clear command written to the configuration address.

Top module: `vsc_top`

## Requirements
- R1: After reset, step_pulse is 0, dout is 0, the address is 0 with done high, both registers hold 0 and the gate is closed, so no source edge steps until the gate is opened.
- R2: Writing wr_data[2:0] with wr_sel=0 picks the step source: 0 drive clock, 1 pod sync, 2 internal oscillator, 3 RAM strobe, 4 decrement; codes 5, 6 and 7 pick no source and no edge steps.
- R3: Configuration bit 7 picks the step edge (1 falling, 0 rising) of the selected source; pod sync is inverted before edge detection, so with bit 7 = 0 it steps on its falling input edge.
- R4: With configuration bit 3 = 1 the enable input is ignored; with bit 3 = 0 a step happens only while enable is at the level given by bit 6 (1 high, 0 low).
- R5: A configuration write (wr_sel=1) with bit 0 = 0 and bit 2 = 0 opens the gate without any START edge; with bit 2 = 1 the gate opens only on a START edge whose polarity bit 4 gives (1 falling, 0 rising).
- R6: With configuration bit 1 = 0 a STOP edge of the polarity in bit 5 (1 falling, 0 rising) closes the gate; with bit 1 = 1 STOP has no effect; a START and a STOP edge in the same cycle leave the gate closed.
- R7: A configuration write with bit 0 = 1 closes the gate and leaves all configuration fields unchanged.
- R8: Each qualifying edge gives exactly one step pulse, high for one cycle, on the third rising clock edge after the input change (two synchronizer stages and one output register).
- R9: Each step decrements the address by one; with drive_mode=1 it also loads vec_data into dout, with drive_mode=0 dout holds.
- R10: done is high exactly when the address is 0; the address never wraps, edges are ignored while done is high, and ld loads ld_value taking priority over a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = source select register, 1 = configuration register |
| wr_data | input | 8 | Write data |
| ld | input | 1 | Load the address counter |
| ld_value | input | ADDR_W | Value for the address counter |
| drive_mode | input | 1 | 1 = drive (capture data on step), 0 = load (decrement only) |
| vec_data | input | DATA_W | Current vector word |
| src_drv | input | 1 | Drive clock source |
| src_pod | input | 1 | Pod sync source (used inverted) |
| src_osc | input | 1 | Internal oscillator source |
| src_strobe | input | 1 | RAM strobe source |
| src_dec | input | 1 | Decrement source |
| ext_enable | input | 1 | External enable |
| ext_start | input | 1 | External start |
| ext_stop | input | 1 | External stop |
| step_pulse | output | 1 | One-cycle step pulse |
| addr | output | ADDR_W | Vector address counter |
| done | output | 1 | Address counter at zero |
| dout | output | DATA_W | Captured vector word |

## Verification
The hardest case to reach is a START and a STOP edge landing in the very same sampled cycle, because the two inputs pass through separate synchronizer bits and any skew splits them. The bench changes both inputs at the same falling clock edge with the gate closed, so both edges reach the gate logic together, and it then pulses the drive clock and expects no step. Pod sync inversion is exposed by checking the step count between the rising and falling halves of a pulse, not only afterwards.

// File: rtl/vsc_pkg.sv
// Package: shared types and helpers for the vector step controller.
// Assumes: configuration is 8 bits wide, with bit 0 used only as a command.
package vsc_pkg;

    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 5;

    // Stored configuration fields (bit 0 is a command, not stored)
    typedef struct packed {
        logic step_fall;     // bit 7
        logic en_high;       // bit 6
        logic stop_fall;     // bit 5
        logic start_fall;    // bit 4
        logic en_always;     // bit 3
        logic start_needed;  // bit 2 (0 = force start)
        logic stop_ignored;  // bit 1 (0 = stop enabled)
    } vsc_cfg_t;

    // Returns 1 when the sampled pair shows an edge of the chosen polarity
    function automatic logic edge_seen(input logic lvl, input logic prev,
                                       input logic fall);
        return fall ? (prev & ~lvl) : (lvl & ~prev);
    endfunction

endpackage

// File: rtl/vsc_sync.sv
// Module: multi-bit synchronizer with one extra history stage.
// Assumes: each bit is independent; lvl is the settled sample and prev the
// sample one cycle older, so callers detect edges from the pair.
module vsc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Later stages settle the sample
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    // History stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= stage_q[STAGES-1];
    end

    assign lvl = stage_q[STAGES-1];
endmodule

// File: rtl/vsc_regs.sv
// Module: write port holding the configuration and source-select registers.
// Assumes: one write per cycle; a configuration write with bit 0 set is a
// clear command and changes no stored field.
module vsc_regs
    import vsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    output vsc_cfg_t         cfg,
    output logic [SEL_W-1:0] src_sel,
    output logic             cmd_clear,
    output logic             cmd_force
);
    logic cfg_wr;
    logic sel_wr;

    // Decode the write into register updates and gate commands
    always_comb begin
        cfg_wr    = wr_en & wr_sel & ~wr_data[0];
        sel_wr    = wr_en & ~wr_sel;
        cmd_clear = wr_en & wr_sel & wr_data[0];
        cmd_force = cfg_wr & ~wr_data[2];
    end

    // Configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (cfg_wr) cfg <= vsc_cfg_t'(wr_data[7:1]);
    end

    // Source-select register
    always_ff @(posedge clk) begin
        if (!rst_n)      src_sel <= '0;
        else if (sel_wr) src_sel <= wr_data[SEL_W-1:0];
    end

    // R7: a clear command leaves stored configuration untouched
    a_r7_clear_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clear && !cfg_wr) |=> $stable(cfg));
endmodule

// File: rtl/vsc_gate.sv
// Module: start/stop gate deciding whether source edges may step.
// Assumes: inputs are synchronized level/history pairs; command pulses are
// one cycle. Priority: clear command, then STOP, then START or force start.
module vsc_gate
    import vsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  vsc_cfg_t cfg,
    input  logic     start_lvl,
    input  logic     start_prev,
    input  logic     stop_lvl,
    input  logic     stop_prev,
    input  logic     cmd_clear,
    input  logic     cmd_force,
    output logic     gate_open
);
    logic start_hit;
    logic stop_hit;

    // Qualify START and STOP edges against their polarity and enables
    always_comb begin
        start_hit = cfg.start_needed &
                    edge_seen(start_lvl, start_prev, cfg.start_fall);
        stop_hit  = ~cfg.stop_ignored &
                    edge_seen(stop_lvl, stop_prev, cfg.stop_fall);
    end

    // Gate state with clear > stop > start priority
    always_ff @(posedge clk) begin
        if (!rst_n)                      gate_open <= 1'b0;
        else if (cmd_clear)              gate_open <= 1'b0;
        else if (stop_hit)               gate_open <= 1'b0;
        else if (start_hit || cmd_force) gate_open <= 1'b1;
    end

    // R6: an enabled STOP edge always leaves the gate closed
    a_r6_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> !gate_open);

    // R7: the clear command always leaves the gate closed
    a_r7_clear_closes: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear |=> !gate_open);

    // R5: a force-start write opens the gate unless stopped at once
    a_r5_force_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_force && !stop_hit) |=> gate_open);
endmodule

// File: rtl/vsc_counter.sv
// Module: vector address counter and drive data register.
// Assumes: step is a one-cycle pulse; ld wins over step; count stops at 0.
module vsc_counter #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_value,
    input  logic              step,
    input  logic              drive_mode,
    input  logic [DATA_W-1:0] vec_data,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output logic              done
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Address counter: load, or decrement on a step while nonzero
    always_ff @(posedge clk) begin
        if (!rst_n)                  addr <= '0;
        else if (ld)                 addr <= ld_value;
        else if (step && addr != 0)  addr <= addr - ONE;
    end

    // Drive data capture on each step in drive mode
    always_ff @(posedge clk) begin
        if (!rst_n)                  dout <= '0;
        else if (step && drive_mode) dout <= vec_data;
    end

    assign done = (addr == '0);

    // R9: a step without load lowers the address by exactly one
    a_r9_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld) |=> (addr == $past(addr) - ONE));

    // R10: the counter never wraps from zero without a load
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && addr == '0) |=> (addr == '0));

    // R9: load mode never changes the captured data
    a_r9_load_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_mode |=> $stable(dout));
endmodule

// File: rtl/vsc_top.sv
// Module: vector step start/stop controller top.
// Assumes: all source and control inputs are asynchronous to clk and stay
// at each level for at least two clk cycles.
module vsc_top
    import vsc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_value,
    input  logic              drive_mode,
    input  logic [DATA_W-1:0] vec_data,
    input  logic              src_drv,
    input  logic              src_pod,
    input  logic              src_osc,
    input  logic              src_strobe,
    input  logic              src_dec,
    input  logic              ext_enable,
    input  logic              ext_start,
    input  logic              ext_stop,
    output logic              step_pulse,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic [DATA_W-1:0] dout
);
    localparam int IN_W   = NUM_SRC + 3;
    localparam int IDX_EN = NUM_SRC;
    localparam int IDX_ST = NUM_SRC + 1;
    localparam int IDX_SP = NUM_SRC + 2;

    vsc_cfg_t         cfg;
    logic [SEL_W-1:0] src_sel;
    logic             cmd_clear, cmd_force, gate_open;
    logic [IN_W-1:0]  raw_in, s_lvl, s_prev;
    logic             sel_lvl, sel_prev, en_ok, step_d;

    // Pod sync enters inverted so vectors change on its falling edge
    assign raw_in = {ext_stop, ext_start, ext_enable,
                     src_dec, src_strobe, src_osc, ~src_pod, src_drv};

    vsc_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .lvl(s_lvl), .prev(s_prev)
    );

    vsc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cfg(cfg), .src_sel(src_sel),
        .cmd_clear(cmd_clear), .cmd_force(cmd_force)
    );

    vsc_gate u_gate (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .start_lvl(s_lvl[IDX_ST]), .start_prev(s_prev[IDX_ST]),
        .stop_lvl(s_lvl[IDX_SP]),  .stop_prev(s_prev[IDX_SP]),
        .cmd_clear(cmd_clear), .cmd_force(cmd_force), .gate_open(gate_open)
    );

    // Source multiplexer; unused codes select a constant low
    always_comb begin
        sel_lvl  = 1'b0;
        sel_prev = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_sel == SEL_W'(i)) begin
                sel_lvl  = s_lvl[i];
                sel_prev = s_prev[i];
            end
        end
    end

    // Enable qualification and step decision
    always_comb begin
        en_ok  = cfg.en_always | (s_lvl[IDX_EN] == cfg.en_high);
        step_d = edge_seen(sel_lvl, sel_prev, cfg.step_fall) &
                 gate_open & en_ok & ~done;
    end

    // Registered one-cycle step pulse
    always_ff @(posedge clk) begin
        if (!rst_n) step_pulse <= 1'b0;
        else        step_pulse <= step_d;
    end

    vsc_counter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_value(ld_value),
        .step(step_d), .drive_mode(drive_mode), .vec_data(vec_data),
        .addr(addr), .dout(dout), .done(done)
    );

    // R8: the step pulse never lasts two cycles
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> !step_pulse);

    // R2: unused select codes never produce a step
    a_r2_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel >= SEL_W'(NUM_SRC)) |=> !step_pulse);

    // R10: no step may be issued while the counter sits at zero
    a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ld) |=> !step_pulse);

    // R6: with the gate closed no step follows
    a_r6_closed_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |=> !step_pulse);
endmodule

// File: tb/vsc_top_test.sv
// Directed bench for the vector step controller.
module vsc_top_test;
    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_sel = 1'b0, ld = 1'b0, drive_mode = 1'b1;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] ld_value = '0;
    logic [DW-1:0] vec_data = '0;
    logic [7:0]    ext = '0;   // 0 drv,1 pod,2 osc,3 strobe,4 dec,5 en,6 start,7 stop
    logic          step_pulse, done;
    logic [AW-1:0] addr;
    logic [DW-1:0] dout;

    int steps = 0;
    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    vsc_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ld(ld), .ld_value(ld_value),
        .drive_mode(drive_mode), .vec_data(vec_data),
        .src_drv(ext[0]), .src_pod(ext[1]), .src_osc(ext[2]),
        .src_strobe(ext[3]), .src_dec(ext[4]), .ext_enable(ext[5]),
        .ext_start(ext[6]), .ext_stop(ext[7]),
        .step_pulse(step_pulse), .addr(addr), .done(done), .dout(dout)
    );

    // Count step pulses, sampled away from the active edge
    always @(negedge clk) if (rst_n && step_pulse) steps <= steps + 1;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic load(input int v);
        @(negedge clk); ld = 1'b1; ld_value = AW'(v);
        @(negedge clk); ld = 1'b0;
    endtask

    // Toggle one input, wait, toggle back; report steps after each half
    task automatic pulse(input int idx, output int d1, output int d2);
        int b;
        @(negedge clk); b = steps; ext[idx] = ~ext[idx];
        repeat (4) @(negedge clk); d1 = steps - b; b = steps;
        ext[idx] = ~ext[idx];
        repeat (4) @(negedge clk); d2 = steps - b;
    endtask

    task automatic t_reset;
        chk("R1 step_pulse", int'(step_pulse), 0);
        chk("R1 addr", int'(addr), 0);
        chk("R1 done", int'(done), 1);
        chk("R1 dout", int'(dout), 0);
        load(5);
        int_pulse_check("R1 closed gate", 0, 0);
    endtask

    task automatic int_pulse_check(input string tag, input int e1, input int e2);
        int a, b;
        pulse(0, a, b);
        chk(tag, a + b, e1 + e2);
    endtask

    task automatic t_step_drive;
        load(10); wr(1'b0, 8'd0);
        vec_data = 16'hABCD; drive_mode = 1'b1;
        wr(1'b1, 8'h0A);   // always enabled, force start, stop ignored
        begin
            int a, b, t0;
            @(negedge clk); t0 = steps; ext[0] = 1'b1;
            repeat (2) @(negedge clk);
            chk("R8 no step before third edge", steps - t0, 0);
            @(negedge clk);
            chk("R8 step on third edge", int'(step_pulse), 1);
            @(negedge clk);
            chk("R8 one cycle wide", int'(step_pulse), 0);
            ext[0] = 1'b0; repeat (4) @(negedge clk);
            chk("R8 one step per edge", steps - t0, 1);
            chk("R9 decrement", int'(addr), 9);
            chk("R9 drive capture", int'(dout), 16'hABCD);
            drive_mode = 1'b0; vec_data = 16'h1234;
            pulse(0, a, b);
            chk("R9 load mode decrements", int'(addr), 8);
            chk("R9 load mode holds dout", int'(dout), 16'hABCD);
            drive_mode = 1'b1;
        end
    endtask

    task automatic t_polarity;
        int a, b;
        load(20);
        wr(1'b1, 8'h8A);   // falling edge
        pulse(0, a, b);
        chk("R3 falling: none on rise", a, 0);
        chk("R3 falling: step on fall", b, 1);
        wr(1'b1, 8'h0A);
        wr(1'b0, 8'd1);    // pod sync
        pulse(1, a, b);
        chk("R3 pod inverted: none on rise", a, 0);
        chk("R3 pod inverted: step on fall", b, 1);
    endtask

    task automatic t_select;
        int a, b;
        load(40);
        wr(1'b1, 8'h0A);
        for (int code = 0; code < 5; code++) begin
            wr(1'b0, 8'(code));
            for (int s = 0; s < 5; s++) begin
                pulse(s, a, b);
                chk($sformatf("R2 code %0d src %0d", code, s), a + b,
                    (s == code) ? 1 : 0);
            end
        end
        for (int code = 5; code < 8; code++) begin
            int tot;
            tot = 0;
            wr(1'b0, 8'(code));
            for (int s = 0; s < 5; s++) begin
                pulse(s, a, b);
                tot += a + b;
            end
            chk($sformatf("R2 unused code %0d", code), tot, 0);
        end
        wr(1'b0, 8'd0);
    endtask

    task automatic t_enable;
        int a, b;
        load(20);
        ext[5] = 1'b0;
        wr(1'b1, 8'h42);   // enable active high, required
        pulse(0, a, b); chk("R4 high-active, en low", a + b, 0);
        ext[5] = 1'b1; repeat (4) @(negedge clk);
        pulse(0, a, b); chk("R4 high-active, en high", a + b, 1);
        wr(1'b1, 8'h02);   // enable active low
        pulse(0, a, b); chk("R4 low-active, en high", a + b, 0);
        ext[5] = 1'b0; repeat (4) @(negedge clk);
        pulse(0, a, b); chk("R4 low-active, en low", a + b, 1);
        ext[5] = 1'b1; repeat (4) @(negedge clk);
        wr(1'b1, 8'h0A);   // always enabled ignores inactive level
        pulse(0, a, b); chk("R4 enable ignored", a + b, 1);
    endtask

    task automatic t_start_clear;
        int a, b;
        load(30);
        ext[5] = 1'b1;     // inactive for low-active enable
        wr(1'b1, 8'h0E);   // start needed, rising, always enabled
        wr(1'b1, 8'h01);   // clear command
        pulse(0, a, b); chk("R7 clear closes gate", a + b, 0);
        pulse(6, a, b);    // start rising
        pulse(0, a, b); chk("R7 fields kept, R5 start opens", a + b, 1);
        wr(1'b1, 8'h1E);   // start on falling edge
        wr(1'b1, 8'h01);
        @(negedge clk); ext[6] = 1'b1; repeat (4) @(negedge clk);
        pulse(0, a, b); chk("R5 no open on rising start", a + b, 0);
        ext[6] = 1'b0; repeat (4) @(negedge clk);
        pulse(0, a, b); chk("R5 open on falling start", a + b, 1);
    endtask

    task automatic t_stop;
        int a, b;
        load(30);
        wr(1'b1, 8'h0C);   // start needed, stop enabled, rising
        wr(1'b1, 8'h01);
        pulse(6, a, b);
        pulse(0, a, b); chk("R6 gate open before stop", a + b, 1);
        pulse(7, a, b);
        pulse(0, a, b); chk("R6 stop closes", a + b, 0);
        wr(1'b1, 8'h0E);   // stop ignored
        pulse(6, a, b);
        pulse(7, a, b);
        pulse(0, a, b); chk("R6 stop ignored", a + b, 1);
        wr(1'b1, 8'h0C);
        wr(1'b1, 8'h01);
        @(negedge clk); ext[6] = 1'b1; ext[7] = 1'b1;
        repeat (4) @(negedge clk); ext[6] = 1'b0; ext[7] = 1'b0;
        repeat (4) @(negedge clk);
        pulse(0, a, b); chk("R6 stop wins same cycle", a + b, 0);
    endtask

    task automatic t_done;
        int a, b, t;
        load(2);
        wr(1'b1, 8'h0A);
        t = 0;
        for (int i = 0; i < 3; i++) begin
            pulse(0, a, b); t += a + b;
        end
        chk("R10 stops at zero", t, 2);
        chk("R10 addr stays zero", int'(addr), 0);
        chk("R10 done high", int'(done), 1);
        load(1);
        chk("R10 done low after load", int'(done), 0);
        pulse(0, a, b); chk("R10 steps after reload", a + b, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_step_drive();
        t_polarity();
        t_select();
        t_enable();
        t_start_clear();
        t_stop();
        t_done();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule